// File: doc/BRIEF.md
# Clock-Control Register Pair with Write Protection

This block keeps two 8-bit control registers for a clock and reset generator and exposes them through a plain register bus: address, write strobe, write data and combinational read data. One register governs the PLL and the clock monitor. The other holds the PLL-select bit and the two "halt on wait" bits. Each bit has its own write rule. Some bits are writable only while a live clock status allows it. One bit locks after the first write in normal chip mode.

From the stored bits and a few status inputs, the block derives the enables that downstream logic consumes. These are the PLL power request and the effective clock-monitor enable, which is suppressed during stop and after a fast wake-up. It also produces the stop-and-clear requests sent to the watchdog counter and to the periodic-interrupt dividers when the chip enters wait. The PLL itself, the clock-loss detector and both counters are outside this block.

Top module: `clkctl_regs`

## Requirements
- R1: After reset the PLL control register (offset 0x06) reads 0xC1, the clock-select register (offset 0x05) reads 0x00, `pll_power` is 1 and `clkmon_en` is 1.
- R2: PLL control bits 5..0 are written and read back as written at any time. Bit 3 is the fast-wake-up enable.
- R3: A write to PLL control bit 7 (clock-monitor enable) has no effect while `scm_active` is 1. The other bits of the same write still take effect.
- R4: A write to PLL control bit 6 (PLL on) has no effect while clock-select bit 7 (PLL select) is 1.
- R5: `pll_power` is 1 whenever `scm_active` is 1. Otherwise it follows PLL control bit 6. A read of bit 6 always returns the last accepted write, whatever `scm_active` is.
- R6: `clkmon_en` is 0 while `stop_active` is 1 and `pseudo_stop` is 0, whatever bit 7 holds. With `pseudo_stop` at 1 it follows bit 7.
- R7: A `stop_wake` pulse while PLL control bit 3 is 1 and `pseudo_stop` is 0 holds `clkmon_en` at 0 from the next cycle on. The hold lasts until the next write to the PLL control register or a reset.
- R8: Clock-select bit 1 (periodic-interrupt halt in wait) and bit 7 (PLL select) can be written at any time. Bits 6..2 read as 0.
- R9: In normal mode (`special_mode` = 0), the first write to the clock-select register locks bit 0 (watchdog halt in wait), whatever data that write carries. Later writes leave bit 0 unchanged until reset.
- R10: In special mode, clock-select bit 0 can be written any number of times.
- R11: In the cycle where `wait_mode` is first seen at 1, `rti_stop_clr` is 1 if clock-select bit 1 is set and `wdog_stop_clr` is 1 if bit 0 is set. Each lasts exactly one cycle.
- R12: Read data is combinational from `addr`. Any address other than the two register offsets reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special chip mode, 0 = normal |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| scm_active | input | 1 | Self-clock mode status |
| pseudo_stop | input | 1 | 1 = stop keeps oscillator running |
| stop_active | input | 1 | Chip is in stop |
| stop_wake | input | 1 | One-cycle wake-from-stop event |
| wait_mode | input | 1 | Chip is in wait |
| pll_power | output | 1 | PLL power request |
| clkmon_en | output | 1 | Effective clock-monitor enable |
| rti_stop_clr | output | 1 | Halt-and-clear request to periodic-interrupt dividers |
| wdog_stop_clr | output | 1 | Halt-and-clear request to watchdog counter |

## Verification
Register writes land on the clock edge that ends the strobe cycle. Read-back, `pll_power` and the stop gating of `clkmon_en` are combinational from that state, so the bench samples them at the following falling edge. The fast-wake hold is registered, so the bench applies the wake pulse for one cycle and checks `clkmon_en` one edge later. The wait requests are combinational in the entry cycle, so the bench checks them 1 ns after raising `wait_mode` and again after the next rising edge, where they must have cleared.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   // PLL control register bit positions
   localparam int PC_CME   = 7;
   localparam int PC_PLLON = 6;
   localparam int PC_FSTWK = 3;
   // clock-select register bit positions
   localparam int CS_PLLSEL = 7;
   localparam int CS_RTIW   = 1;
   localparam int CS_WDW    = 0;
   localparam logic [7:0] CS_MASK = 8'h83;
endpackage

// File: rtl/clkctl_pllreg.sv
module clkctl_pllreg
   import clkctl_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter logic [7:0] RST_VAL = 8'hC1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              scm_active,
   input  logic              pll_sel,
   output logic [DATA_W-1:0] reg_q
);
   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = reg_q;
      if (wr) begin
         nxt[PC_PLLON-1:0] = wdata[PC_PLLON-1:0];
         if (!scm_active) nxt[PC_CME]   = wdata[PC_CME];
         if (!pll_sel)    nxt[PC_PLLON] = wdata[PC_PLLON];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= RST_VAL;
      else        reg_q <= nxt;
   end
endmodule

// File: rtl/clkctl_selreg.sv
module clkctl_selreg
   import clkctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              special_mode,
   output logic [DATA_W-1:0] reg_q,
   output logic              lock_q
);
   logic [DATA_W-1:0] nxt;
   logic              lock_nxt;

   always_comb begin
      nxt      = reg_q;
      lock_nxt = lock_q;
      if (wr) begin
         nxt[CS_PLLSEL] = wdata[CS_PLLSEL];
         nxt[CS_RTIW]   = wdata[CS_RTIW];
         if (special_mode || !lock_q) nxt[CS_WDW] = wdata[CS_WDW];
         if (!special_mode) lock_nxt = 1'b1;
      end
      nxt = nxt & CS_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         reg_q  <= nxt;
         lock_q <= lock_nxt;
      end
   end
endmodule

// File: rtl/clkctl_waitstop.sv
module clkctl_waitstop #(
   parameter bit WAIT_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_mode,
   input  logic rti_en,
   input  logic wdog_en,
   output logic rti_stop_clr,
   output logic wdog_stop_clr
);
   logic fire;

   generate
      if (WAIT_EDGE) begin : g_edge
         logic wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wait_q <= 1'b0;
            else        wait_q <= wait_mode;
         end
         assign fire = wait_mode & ~wait_q;
      end else begin : g_level
         assign fire = wait_mode;
      end
   endgenerate

   assign rti_stop_clr  = fire & rti_en;
   assign wdog_stop_clr = fire & wdog_en;
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] PLL_OFS   = 8'h06,
   parameter logic [7:0] SEL_OFS   = 8'h05,
   parameter logic [7:0] PLL_RST   = 8'hC1,
   parameter bit         WAIT_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              scm_active,
   input  logic              pseudo_stop,
   input  logic              stop_active,
   input  logic              stop_wake,
   input  logic              wait_mode,
   output logic              pll_power,
   output logic              clkmon_en,
   output logic              rti_stop_clr,
   output logic              wdog_stop_clr
);
   localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(PLL_OFS);
   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);

   if (DATA_W != 8) begin : g_bad_width
      $error("clkctl_regs: DATA_W must be 8");
   end
   if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_addr
      $error("clkctl_regs: ADDR_W out of range");
   end
   if (PLL_OFS == SEL_OFS) begin : g_bad_ofs
      $error("clkctl_regs: register offsets collide");
   end

   logic              hit_pll, hit_sel, wr_pll, wr_sel;
   logic [DATA_W-1:0] pll_reg, sel_reg;
   logic              wdog_lock, fw_hold;

   assign hit_pll = (addr == PLL_A);
   assign hit_sel = (addr == SEL_A);
   assign wr_pll  = wr_en & hit_pll;
   assign wr_sel  = wr_en & hit_sel;

   clkctl_pllreg #(.DATA_W(DATA_W), .RST_VAL(PLL_RST)) u_pll (
      .clk(clk), .rst_n(rst_n), .wr(wr_pll), .wdata(wr_data),
      .scm_active(scm_active), .pll_sel(sel_reg[CS_PLLSEL]), .reg_q(pll_reg)
   );

   clkctl_selreg #(.DATA_W(DATA_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr(wr_sel), .wdata(wr_data),
      .special_mode(special_mode), .reg_q(sel_reg), .lock_q(wdog_lock)
   );

   clkctl_waitstop #(.WAIT_EDGE(WAIT_EDGE)) u_wait (
      .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode),
      .rti_en(sel_reg[CS_RTIW]), .wdog_en(sel_reg[CS_WDW]),
      .rti_stop_clr(rti_stop_clr), .wdog_stop_clr(wdog_stop_clr)
   );

   // fast wake-up hold of the clock monitor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fw_hold <= 1'b0;
      else if (stop_wake && pll_reg[PC_FSTWK] && !pseudo_stop)
         fw_hold <= 1'b1;
      else if (wr_pll)
         fw_hold <= 1'b0;
   end

   assign pll_power = pll_reg[PC_PLLON] | scm_active;
   assign clkmon_en = pll_reg[PC_CME] & ~(stop_active & ~pseudo_stop) & ~fw_hold;

   always_comb begin
      if (hit_pll)      rd_data = pll_reg;
      else if (hit_sel) rd_data = sel_reg;
      else              rd_data = '0;
   end
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk
   import clkctl_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter logic [7:0] PLL_OFS   = 8'h06,
   parameter logic [7:0] SEL_OFS   = 8'h05,
   parameter bit         WAIT_EDGE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              special_mode,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              scm_active,
   input logic              pseudo_stop,
   input logic              stop_active,
   input logic              stop_wake,
   input logic              clkmon_en,
   input logic              pll_power,
   input logic              rti_stop_clr,
   input logic              wdog_stop_clr,
   input logic [7:0]        pll_reg,
   input logic [7:0]        sel_reg,
   input logic              wdog_lock
);
   logic wp, ws;
   assign wp = wr_en && (addr == ADDR_W'(PLL_OFS));
   assign ws = wr_en && (addr == ADDR_W'(SEL_OFS));

   // R3
   a_r3_cme_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && scm_active) |=> (pll_reg[PC_CME] == $past(pll_reg[PC_CME])));
   // R4
   a_r4_pllon_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && sel_reg[CS_PLLSEL]) |=> (pll_reg[PC_PLLON] == $past(pll_reg[PC_PLLON])));
   // R5
   a_r5_scm_power: assert property (@(posedge clk) disable iff (!rst_n)
      scm_active |-> pll_power);
   // R6
   a_r6_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && !pseudo_stop) |-> !clkmon_en);
   // R7
   a_r7_fastwake_off: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_wake && pll_reg[PC_FSTWK] && !pseudo_stop) |=> !clkmon_en);
   // R9
   a_r9_wdog_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (ws && wdog_lock && !special_mode) |=> $stable(sel_reg[CS_WDW]));
   // R11
   a_r11_rti_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (WAIT_EDGE && rti_stop_clr) |=> !rti_stop_clr);
   a_r11_wdog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (WAIT_EDGE && wdog_stop_clr) |=> !wdog_stop_clr);
   // R8
   a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_reg & ~CS_MASK) == 8'h00);
endmodule

bind clkctl_regs clkctl_regs_chk #(
   .ADDR_W(ADDR_W), .PLL_OFS(PLL_OFS), .SEL_OFS(SEL_OFS), .WAIT_EDGE(WAIT_EDGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .addr(addr),
   .wr_en(wr_en), .scm_active(scm_active), .pseudo_stop(pseudo_stop),
   .stop_active(stop_active), .stop_wake(stop_wake), .clkmon_en(clkmon_en),
   .pll_power(pll_power), .rti_stop_clr(rti_stop_clr), .wdog_stop_clr(wdog_stop_clr),
   .pll_reg(pll_reg), .sel_reg(sel_reg), .wdog_lock(wdog_lock)
);

// File: tb/clkctl_regs_bench.sv
module clkctl_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_mode = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       scm_active = 1'b0, pseudo_stop = 1'b0, stop_active = 1'b0;
   logic       stop_wake = 1'b0, wait_mode = 1'b0;
   logic       pll_power, clkmon_en, rti_stop_clr, wdog_stop_clr;
   int         checks = 0, errors = 0;

   localparam logic [7:0] PA = 8'h06, SA = 8'h05;

   always #4 clk = ~clk;   // 125 MHz

   clkctl_regs u_clkctl_regs (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .scm_active(scm_active), .pseudo_stop(pseudo_stop), .stop_active(stop_active),
      .stop_wake(stop_wake), .wait_mode(wait_mode), .pll_power(pll_power),
      .clkmon_en(clkmon_en), .rti_stop_clr(rti_stop_clr), .wdog_stop_clr(wdog_stop_clr)
   );

   typedef struct packed {
      logic       to_sel;
      logic [7:0] data;
      logic       scm;
      logic [7:0] exp;
   } vec_t;

   // walked from reset in normal mode; expected read-back of the written register
   localparam vec_t VECS [8] = '{
      '{1'b0, 8'h3E, 1'b0, 8'h3E},   // R2 free bits, CME/PLLON cleared
      '{1'b0, 8'hC0, 1'b1, 8'h40},   // R3 CME blocked by self-clock mode
      '{1'b0, 8'h95, 1'b0, 8'h95},   // R2 R3 CME accepted again
      '{1'b1, 8'h83, 1'b0, 8'h83},   // R8 R9 first select write, locks bit 0
      '{1'b0, 8'h40, 1'b0, 8'h00},   // R4 PLLON blocked by PLL select
      '{1'b1, 8'h00, 1'b0, 8'h01},   // R8 R9 bit 0 stays set
      '{1'b0, 8'h7F, 1'b0, 8'h7F},   // R4 PLLON accepted after select cleared
      '{1'b1, 8'hFE, 1'b0, 8'h83}    // R8 R9 upper bits masked, bit 0 locked
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      read_chk("R1 pll reg", PA, 8'hC1);
      read_chk("R1 sel reg", SA, 8'h00);
      check("R1 pll_power", {7'd0, pll_power}, 8'h01);
      check("R1 clkmon_en", {7'd0, clkmon_en}, 8'h01);
      // R12 unmapped reads
      read_chk("R12 unmapped 0x00", 8'h00, 8'h00);
      read_chk("R12 unmapped 0x07", 8'h07, 8'h00);

      // vector table
      for (int i = 0; i < 8; i++) begin
         scm_active = VECS[i].scm;
         do_write(VECS[i].to_sel ? SA : PA, VECS[i].data);
         read_chk($sformatf("R2/R3/R4/R8/R9 vector %0d", i),
                  VECS[i].to_sel ? SA : PA, VECS[i].exp);
         scm_active = 1'b0;
      end

      // R5 forced power, read-back unchanged
      do_reset();
      do_write(PA, 8'h81);                 // PLLON cleared
      read_chk("R5 pllon readback", PA, 8'h81);
      check("R5 power off", {7'd0, pll_power}, 8'h00);
      scm_active = 1'b1; #1;
      check("R5 power forced by scm", {7'd0, pll_power}, 8'h01);
      read_chk("R5 readback under scm", PA, 8'h81);
      scm_active = 1'b0;

      // R6 stop gating
      stop_active = 1'b1; pseudo_stop = 1'b1; #1;
      check("R6 pseudo stop keeps monitor", {7'd0, clkmon_en}, 8'h01);
      pseudo_stop = 1'b0; #1;
      check("R6 full stop disables monitor", {7'd0, clkmon_en}, 8'h00);

      // R7 fast wake hold
      do_write(PA, 8'h89);                 // CME=1, fast wake=1
      @(negedge clk);
      stop_wake = 1'b1; stop_active = 1'b0;
      @(negedge clk);
      stop_wake = 1'b0;
      check("R7 held off after fast wake", {7'd0, clkmon_en}, 8'h00);
      repeat (3) @(negedge clk);
      check("R7 still held", {7'd0, clkmon_en}, 8'h00);
      do_write(PA, 8'h81);
      check("R7 released by write", {7'd0, clkmon_en}, 8'h01);

      // R10 special mode rewrites
      do_reset();
      special_mode = 1'b1;
      do_write(SA, 8'h01);
      read_chk("R10 first write", SA, 8'h01);
      do_write(SA, 8'h00);
      read_chk("R10 second write", SA, 8'h00);
      do_write(SA, 8'h01);
      read_chk("R10 third write", SA, 8'h01);
      special_mode = 1'b0;

      // R9 lock by zero-data write
      do_reset();
      do_write(SA, 8'h00);
      do_write(SA, 8'h01);
      read_chk("R9 lock from first write", SA, 8'h00);
      // R8 RTI bit after lock
      do_write(SA, 8'h02);
      read_chk("R8 rti bit writable", SA, 8'h02);

      // R11 wait entry pulses (rti=1, wdog=0)
      wait_mode = 1'b1; #1;
      check("R11 rti pulse", {7'd0, rti_stop_clr}, 8'h01);
      check("R11 no wdog pulse", {7'd0, wdog_stop_clr}, 8'h00);
      @(posedge clk); #1;
      check("R11 rti pulse ends", {7'd0, rti_stop_clr}, 8'h00);
      @(negedge clk);
      wait_mode = 1'b0;
      do_reset();
      special_mode = 1'b1;
      do_write(SA, 8'h01);
      special_mode = 1'b0;
      wait_mode = 1'b1; #1;
      check("R11 wdog pulse", {7'd0, wdog_stop_clr}, 8'h01);
      check("R11 no rti pulse", {7'd0, rti_stop_clr}, 8'h00);
      @(posedge clk); #1;
      check("R11 wdog pulse ends", {7'd0, wdog_stop_clr}, 8'h00);
      wait_mode = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule